// File: doc/BRIEF.md
# ECC Address Range Filter

This block decides, for each memory access, whether error-correcting-code generation and checking apply to it. A mode register and two window registers, loaded over a simple register bus, set the policy. Each access presents a 32-bit offset from the memory base. One clock after that strobe, the block returns a qualified "protected" flag.

The mode register holds a master enable and a region-only switch. When the region-only switch is off and the master enable is on, every access is protected. When the region-only switch is on, only offsets that fall inside an enabled window are protected. Each window has a 64 KiB granularity. Its lower bound is a 16-bit page number with implied low bits of zero. Its upper bound is a 16-bit page number with implied low bits of all ones. Both bounds are inclusive. Overlapping windows are allowed, and their matches simply combine.

Top module: `ecc_range_filter`

## Requirements
- R1: After reset, all three registers read zero, `prot_valid` is low and `prot_flag` is low.
- R2: Register index 1 is window one and index 2 is window two. Each window register reads back the full 32-bit value written. Bits 31:16 hold the upper page and bits 15:0 hold the lower page.
- R3: Register index 0 is the mode register. Its bits 29:2 always read zero and writes to them are dropped. Register index 3 always reads zero and writes to it change nothing.
- R4: While mode bit 31 (master enable) is clear, no access is protected, whatever the other settings are.
- R5: While mode bit 31 is set and mode bit 30 (region-only) is clear, every access is protected.
- R6: While mode bits 31 and 30 are both set, an access is protected exactly when its offset lies in an enabled window. The window spans {lower page, 16'h0000} through {upper page, 16'hFFFF}, and both ends are inclusive.
- R7: Mode bit 0 enables window one and mode bit 1 enables window two. A window whose enable bit is clear matches no offset.
- R8: When two enabled windows overlap, an offset in either window is protected, and the overlap has no further effect.
- R9: `prot_valid` is high in exactly the cycle after a cycle in which `acc_valid` is high. In that cycle, `prot_flag` gives the decision made from the offset and the registers as they stood in the strobe cycle. When `prot_valid` is low, `prot_flag` is low.
- R10: A window whose lower page is greater than its upper page matches no offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index (0 mode, 1 window one, 2 window two) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the register selected by `cfg_addr` |
| acc_valid | input | 1 | Access strobe |
| acc_offset | input | 32 | Access offset from the memory base |
| prot_valid | output | 1 | Decision valid, one cycle after the strobe |
| prot_flag | output | 1 | Access is ECC protected |

## Verification
The bench targets the inclusive window edges: the first byte of the lower page, the last byte of the upper page, and one byte outside each. A design that compared full 32-bit bounds, or that treated a bound as exclusive, would misclassify exactly those offsets.

It also covers a window at the very top of the address space, and windows whose lower page is above the upper page. A wrong comparison would then wrap around and protect everything.

Other cases drive the reserved mode bits with ones and write to the unused index. A design that stored those bits would read them back nonzero.

Finally, the bench overlaps the windows, disables one window while leaving its bounds in place, and switches off the master enable while region-only stays set. A design with a wrong combination term would then protect the wrong accesses or ignore an enable bit.

// File: rtl/ecc_rf_pkg.sv
package ecc_rf_pkg;

    parameter int ADDR_W    = 32;
    parameter int DATA_W    = 32;
    parameter int GRAN_BITS = 16;
    parameter int NUM_WIN   = 2;
    parameter int BOUND_W   = ADDR_W - GRAN_BITS;

    parameter int MODE_MASTER_BIT = 31;
    parameter int MODE_REGION_BIT = 30;

    typedef struct packed {
        logic [BOUND_W-1:0] hi_page;
        logic [BOUND_W-1:0] lo_page;
    } win_reg_t;

    typedef struct packed {
        logic                    master_en;
        logic                    region_only;
        logic [NUM_WIN-1:0]      win_en;
        win_reg_t [NUM_WIN-1:0]  win;
    } reg_state_t;

    typedef struct packed {
        logic valid;
        logic flag;
    } decide_state_t;

endpackage

// File: rtl/ecc_rf_regs.sv
module ecc_rf_regs
    import ecc_rf_pkg::*;
#(
    parameter int P_NUM_WIN = NUM_WIN,
    parameter int P_DATA_W  = DATA_W,
    localparam int CFG_AW   = $clog2(P_NUM_WIN + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CFG_AW-1:0]            addr,
    input  logic [P_DATA_W-1:0]          wdata,
    output logic [P_DATA_W-1:0]          rdata,
    output logic                         master_en,
    output logic                         region_only,
    output logic [P_NUM_WIN-1:0]         win_en,
    output win_reg_t [P_NUM_WIN-1:0]     win_cfg
);

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en && addr == '0) begin
            state_d.master_en   = wdata[MODE_MASTER_BIT];
            state_d.region_only = wdata[MODE_REGION_BIT];
            state_d.win_en      = wdata[P_NUM_WIN-1:0];
        end
        for (int i = 0; i < P_NUM_WIN; i++) begin
            if (wr_en && addr == CFG_AW'(i + 1)) begin
                state_d.win[i] = wdata[2*BOUND_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata[MODE_MASTER_BIT] = state_q.master_en;
            rdata[MODE_REGION_BIT] = state_q.region_only;
            rdata[P_NUM_WIN-1:0]   = state_q.win_en;
        end
        for (int i = 0; i < P_NUM_WIN; i++) begin
            if (addr == CFG_AW'(i + 1)) begin
                rdata[2*BOUND_W-1:0] = state_q.win[i];
            end
        end
    end

    assign master_en   = state_q.master_en;
    assign region_only = state_q.region_only;
    assign win_en      = state_q.win_en;
    assign win_cfg     = state_q.win;

endmodule

// File: rtl/ecc_rf_window.sv
module ecc_rf_window
    import ecc_rf_pkg::*;
(
    input  logic               en,
    input  win_reg_t           cfg,
    input  logic [BOUND_W-1:0] page,
    output logic               hit
);

    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (page >= cfg.lo_page);
        below_hi = (page <= cfg.hi_page);
        hit      = en && above_lo && below_hi;
    end

endmodule

// File: rtl/ecc_range_filter.sv
module ecc_range_filter
    import ecc_rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        acc_valid,
    input  logic [31:0] acc_offset,
    output logic        prot_valid,
    output logic        prot_flag
);

    logic                    master_en;
    logic                    region_only;
    logic [NUM_WIN-1:0]      win_en;
    win_reg_t [NUM_WIN-1:0]  win_cfg;
    logic [NUM_WIN-1:0]      win_hit;
    logic [BOUND_W-1:0]      acc_page;

    decide_state_t dec_d, dec_q;

    ecc_rf_regs #(
        .P_NUM_WIN (NUM_WIN),
        .P_DATA_W  (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .rdata       (cfg_rdata),
        .master_en   (master_en),
        .region_only (region_only),
        .win_en      (win_en),
        .win_cfg     (win_cfg)
    );

    assign acc_page = acc_offset[ADDR_W-1:GRAN_BITS];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        ecc_rf_window u_win (
            .en   (win_en[g]),
            .cfg  (win_cfg[g]),
            .page (acc_page),
            .hit  (win_hit[g])
        );
    end

    always_comb begin
        dec_d.valid = acc_valid;
        dec_d.flag  = acc_valid && master_en && (!region_only || (|win_hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign prot_valid = dec_q.valid;
    assign prot_flag  = dec_q.flag;

endmodule

// File: rtl/ecc_range_filter_chk.sv
module ecc_range_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        prot_valid,
    input logic        prot_flag,
    input logic        master_en,
    input logic        region_only,
    input logic [1:0]  win_hit,
    input logic [1:0]  cfg_addr,
    input logic [31:0] cfg_rdata
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> prot_valid); // R9
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !prot_valid); // R9
    AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_valid |-> !prot_flag); // R9
    AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !master_en) |=> !prot_flag); // R4
    AST_ALL_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && master_en && !region_only) |=> prot_flag); // R5
    AST_REGION_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && master_en && region_only && win_hit == 2'b00) |=> !prot_flag); // R6
    AST_REGION_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && master_en && region_only && win_hit != 2'b00) |=> prot_flag); // R8
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 2'd0) |-> (cfg_rdata[29:2] == '0)); // R3
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 2'd3) |-> (cfg_rdata == '0)); // R3

endmodule

bind ecc_range_filter ecc_range_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .prot_valid  (prot_valid),
    .prot_flag   (prot_flag),
    .master_en   (master_en),
    .region_only (region_only),
    .win_hit     (win_hit),
    .cfg_addr    (cfg_addr),
    .cfg_rdata   (cfg_rdata)
);

// File: tb/sim_ecc_range_filter.sv
module sim_ecc_range_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_offset = '0;
    logic        prot_valid;
    logic        prot_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_mode = '0;
    logic [31:0] m_w1 = '0;
    logic [31:0] m_w2 = '0;

    always #2.5 clk = ~clk;

    ecc_range_filter u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .acc_valid  (acc_valid),
        .acc_offset (acc_offset),
        .prot_valid (prot_valid),
        .prot_flag  (prot_flag)
    );

    function automatic bit in_win(logic [31:0] w, logic [31:0] off);
        logic [31:0] lo_b, hi_b;
        lo_b = {w[15:0], 16'h0000};
        hi_b = {w[31:16], 16'hFFFF};
        return (off >= lo_b) && (off <= hi_b);
    endfunction

    function automatic bit exp_prot(logic [31:0] mode, logic [31:0] w1,
                                    logic [31:0] w2, logic [31:0] off);
        bit h;
        if (!mode[31]) return 1'b0;
        if (!mode[30]) return 1'b1;
        h = (mode[0] && in_win(w1, off)) || (mode[1] && in_win(w2, off));
        return h;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (a)
            2'd0: m_mode = d & 32'hC000_0003;
            2'd1: m_w1 = d;
            2'd2: m_w2 = d;
            default: ;
        endcase
    endtask

    task automatic rd_check(logic [1:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic access(logic [31:0] off, string tag);
        bit e;
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_offset = off;
        e = exp_prot(m_mode, m_w1, m_w2, off);
        @(negedge clk);
        acc_valid = 1'b0;
        check(prot_valid == 1'b1, "R9 valid", {31'b0, prot_valid}, 32'h1);
        check(prot_flag == e, tag, {31'b0, prot_flag}, {31'b0, e});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(prot_valid == 1'b0, "R1 valid", {31'b0, prot_valid}, 32'h0);
        check(prot_flag == 1'b0, "R1 flag", {31'b0, prot_flag}, 32'h0);
        rd_check(2'd0, 32'h0, "R1 mode");
        rd_check(2'd1, 32'h0, "R1 win1");
        rd_check(2'd2, 32'h0, "R1 win2");
        access(32'h1234_5678, "R1 R4 off after reset");

        // R3 reserved bits, spare index
        wr(2'd0, 32'hFFFF_FFFF);
        rd_check(2'd0, 32'hC000_0003, "R3 mode reserved");
        wr(2'd3, 32'hDEAD_BEEF);
        rd_check(2'd3, 32'h0, "R3 spare index");
        rd_check(2'd1, 32'h0, "R3 spare no side effect");

        // R2 window readback
        wr(2'd1, 32'h0FFF_0000);
        wr(2'd2, 32'h1FFF_1000);
        rd_check(2'd1, 32'h0FFF_0000, "R2 win1");
        rd_check(2'd2, 32'h1FFF_1000, "R2 win2");

        // R5 all protected
        wr(2'd0, 32'h8000_0000);
        access(32'hF000_0000, "R5 all protected high");
        access(32'h0000_0000, "R5 all protected low");

        // R6 region edges
        wr(2'd0, 32'hC000_0001);
        access(32'h0000_0000, "R6 lower edge");
        access(32'h0FFF_FFFF, "R6 upper edge");
        access(32'h1000_0000, "R6 just above");
        // R7 window two disabled
        access(32'h1800_0000, "R7 win2 disabled");
        wr(2'd0, 32'hC000_0002);
        access(32'h1800_0000, "R7 win2 enabled");
        access(32'h0800_0000, "R7 win1 disabled");
        access(32'h0FFF_FFFF, "R6 below win2 lower edge");

        // R4 master off with region set
        wr(2'd0, 32'h4000_0003);
        access(32'h0800_0000, "R4 master off");

        // R8 overlap
        wr(2'd1, 32'h0040_0010);
        wr(2'd2, 32'h0050_0030);
        wr(2'd0, 32'hC000_0003);
        access(32'h0035_0000, "R8 overlap");
        access(32'h0050_FFFF, "R8 win2 only");
        access(32'h0051_0000, "R8 beyond both");

        // top of space
        wr(2'd1, 32'hFFFF_FFF0);
        access(32'hFFFF_FFFF, "R6 top of space");

        // R10 inverted window
        wr(2'd1, 32'h0010_0020);
        wr(2'd2, 32'h0000_FFFF);
        access(32'h0018_0000, "R10 inverted win1");
        access(32'h0000_0000, "R10 inverted win2");

        // R9 no strobe -> no valid
        @(negedge clk);
        check(prot_valid == 1'b0, "R9 idle valid", {31'b0, prot_valid}, 32'h0);
        check(prot_flag == 1'b0, "R9 idle flag", {31'b0, prot_flag}, 32'h0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom % 8;
            if (sel == 0) begin
                wr(2'd0, $urandom);
            end else if (sel == 1) begin
                wr(2'($urandom % 2 + 1), {16'($urandom % 16), 16'($urandom % 16)});
            end else begin
                access({16'($urandom % 18), 16'($urandom)}, "R6 random");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule